// File: doc/BRIEF.md
# PME Status and Pending Register

This block is the root-side status word that records power management event (PME) messages coming up from downstream requesters. When an event is accepted, the block captures the sender's 16-bit requester ID and raises a status flag. Software acknowledges the event by writing a one to that flag.

Events that arrive while the flag is still raised are not lost. They wait in a small first-in first-out queue, and a pending flag tells software that more are waiting. Each time software acknowledges, the oldest waiting event is handed over automatically. Its ID then appears and the status flag rises again.

The block sits behind a simple register port. The port has a byte address, 32-bit write data, a write enable and a read enable. Reads return data one cycle after the request. A sticky debug output reports that the queue once had to discard an event.

Top module: `pme_root_status`

## Requirements
- R1: After reset the register reads 0x00000000. Bits 31:18 always read as zero, and writing ones to them changes nothing.
- R2: With the status flag (bit 16) at 0 and the queue empty, a PME accepted on a clock edge sets bit 16 and loads its ID into bits 15:0 at that same edge.
- R3: Writing 1 to bit 16 clears it. Writing 0 to bit 16 leaves it unchanged, and bits 15:0 cannot be written by software.
- R4: While bit 16 is 1, an arriving PME is queued instead of delivered, and bits 15:0 keep their value.
- R5: Bit 17 reads 1 exactly while at least one PME waits in the queue.
- R6: After a clearing write with events queued, a read in the next cycle shows bit 16 at 0. The following cycle shows bit 16 at 1 with the oldest queued ID, so events are handed over in arrival order.
- R7: If a clearing write and a new PME meet in the same cycle with the queue empty, the clear takes effect first. The new PME is delivered one cycle later.
- R8: A PME arriving while the queue holds QDEPTH (default 4) events is discarded. The output dbg_overflow then rises and stays high until reset.
- R9: A read request is answered one cycle later with reg_rvalid high. A read of any address other than the register's word (byte offset 0xC0 by default, bits 1:0 ignored) returns zero.
- R10: Writes to any other word address have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pme_valid | input | 1 | A PME message is presented this cycle |
| pme_rid | input | 16 | Requester ID of the presented PME |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read enable |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data returned this cycle |
| dbg_overflow | output | 1 | Sticky flag: a PME was discarded because the queue was full |

## Verification
The bench reads the register in the cycle just after an acknowledge. A design that re-delivered at the clearing edge itself would show status still 1 there, and a design that waited too long would still show 0 one cycle later.

It collides an acknowledge with a fresh PME on an empty queue. A design that let the arrival win would keep the old ID or lose the new event.

It fills the queue past its depth and drains it. Wrong ordering, a stored fifth event or a non-sticky overflow flag each show up as a wrong ID or a wrong flag.

Zero-writes, writes to other words and reads of other words are also covered. These catch decoding that is too loose and a bit 16 that clears on any write.

// File: rtl/pme_root_status.sv
module pme_root_status #(
  parameter int RID_W = 16,
  parameter int QDEPTH = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pme_valid,
  input  logic [RID_W-1:0]  pme_rid,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_re,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              dbg_overflow
);
  localparam int CW = $clog2(QDEPTH + 1);
  localparam int PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int STAT_BIT = 16;
  localparam logic [PW-1:0] LAST = PW'(QDEPTH - 1);

  logic             status_q;
  logic [RID_W-1:0] rid_q;
  logic [CW-1:0]    cnt_q;
  logic [PW-1:0]    wp_q, rp_q;
  logic [RID_W-1:0] mem [QDEPTH];

  wire hit    = reg_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2];
  wire clr    = reg_we && hit && reg_wdata[STAT_BIT] && status_q;
  wire empty  = cnt_q == '0;
  wire full   = cnt_q == CW'(QDEPTH);
  wire pop    = !status_q && !empty;
  wire direct = !status_q && empty && pme_valid;
  wire push   = pme_valid && !direct && (!full || pop);
  wire drop   = pme_valid && !direct && full && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= pme_rid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q     <= 1'b0;
      rid_q        <= '0;
      cnt_q        <= '0;
      wp_q         <= '0;
      rp_q         <= '0;
      dbg_overflow <= 1'b0;
    end else begin
      if (clr)                status_q <= 1'b0;
      else if (pop || direct) status_q <= 1'b1;
      if (pop)         rid_q <= mem[rp_q];
      else if (direct) rid_q <= pme_rid;
      if (push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      if (drop) dbg_overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_re;
      reg_rdata  <= (reg_re && hit) ? {14'b0, !empty, status_q, rid_q} : '0;
    end
  end
endmodule

// File: rtl/pme_root_status_chk.sv
module pme_root_status_chk #(
  parameter int RID_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pme_valid,
  input logic [RID_W-1:0]  pme_rid,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              reg_re,
  input logic [31:0]       reg_rdata,
  input logic              reg_rvalid,
  input logic              dbg_overflow,
  input logic              status,
  input logic              pend,
  input logic [RID_W-1:0]  rid
);
  logic ack_wr;
  assign ack_wr = reg_we && reg_wdata[16] && (reg_addr[ADDR_W-1:2] == REG_ADDR[ADDR_W-1:2]);

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> reg_rdata[31:18] == '0);
  p_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !pend && pme_valid) |=> (status && rid == $past(pme_rid)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status && ack_wr) |=> !status);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !ack_wr) |=> (status && $stable(rid)));
  p_redeliver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && pend) |=> status);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_overflow |=> dbg_overflow);
  p_rd_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> reg_rvalid);
  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> !reg_rvalid);
endmodule

bind pme_root_status pme_root_status_chk #(
  .RID_W(RID_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pme_valid(pme_valid), .pme_rid(pme_rid),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .dbg_overflow(dbg_overflow),
  .status(status_q), .pend(!empty), .rid(rid_q)
);

// File: tb/sim_pme_root_status.sv
module sim_pme_root_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RA = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pme_valid = 1'b0;
  logic [15:0] pme_rid = '0;
  logic [7:0] reg_addr = RA;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic dbg_overflow;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_root_status u0 (
    .clk(clk), .rst_n(rst_n), .pme_valid(pme_valid), .pme_rid(pme_rid),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .dbg_overflow(dbg_overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, reg_rdata, e);
      end
    end
  end

  task automatic pme(input logic [15:0] id);
    pme_valid = 1'b1; pme_rid = id;
    @(negedge clk);
    pme_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = RA;
  endtask

  task automatic wr_pme(input logic [31:0] d, input logic [15:0] id);
    reg_we = 1'b1; reg_wdata = d; pme_valid = 1'b1; pme_rid = id;
    @(negedge clk);
    reg_we = 1'b0; pme_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0; reg_addr = RA;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rvalid idle", {31'b0, reg_rvalid}, 32'h0);
    rd(RA, 32'h0, "R1 reset value");
    wr(RA, 32'hFFFF_FFFF);
    rd(RA, 32'h0, "R1 R3 write ignored while idle");
    pme(16'h1234);
    rd(RA, 32'h0001_1234, "R2 direct delivery");
    wr(RA, 32'h0000_0000);
    rd(RA, 32'h0001_1234, "R3 write 0 keeps status");
    wr(RA, 32'hFFFE_FFFF);
    rd(RA, 32'h0001_1234, "R3 ID read-only");
    wr(8'hC4, 32'h0001_0000);
    rd(RA, 32'h0001_1234, "R10 other address write");
    rd(8'hC4, 32'h0, "R9 other address read");
    rd(8'hC2, 32'h0001_1234, "R9 low address bits ignored");
    pme(16'hAAAA);
    pme(16'hBBBB);
    rd(RA, 32'h0003_1234, "R4 R5 queued while set");
    wr(RA, 32'h0001_0000);
    rd(RA, 32'h0002_1234, "R6 gap cycle status 0");
    rd(RA, 32'h0003_AAAA, "R6 first queued ID");
    wr(RA, 32'h0001_0000);
    rd(RA, 32'h0002_AAAA, "R6 gap cycle");
    rd(RA, 32'h0001_BBBB, "R5 R6 last queued, pending clear");
    wr_pme(32'h0001_0000, 16'h5555);
    rd(RA, 32'h0002_BBBB, "R7 clear wins");
    rd(RA, 32'h0001_5555, "R7 delivered next cycle");
    pme(16'h0001); pme(16'h0002); pme(16'h0003); pme(16'h0004);
    check("R8 no overflow at full", {31'b0, dbg_overflow}, 32'h0);
    pme(16'h0005);
    check("R8 overflow raised", {31'b0, dbg_overflow}, 32'h1);
    rd(RA, 32'h0003_5555, "R4 ID held when full");
    for (int i = 1; i <= 4; i++) begin
      wr(RA, 32'h0001_0000);
      rd(RA, 32'h0002_0000 | (i - 1 == 0 ? 32'h5555 : 32'(i - 1)), "R6 drain gap");
      rd(RA, (i < 4 ? 32'h0003_0000 : 32'h0001_0000) | 32'(i), "R6 R8 drain order");
    end
    wr(RA, 32'h0001_0000);
    rd(RA, 32'h0000_0004, "R8 dropped event absent");
    rd(RA, 32'h0000_0004, "R8 nothing redelivered");
    check("R8 overflow sticky", {31'b0, dbg_overflow}, 32'h1);
    repeat (2) @(negedge clk);
    check("R9 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule